// File: doc/BRIEF.md
# Memory Fault Capture and Interrupt Unit

This unit sits beside a memory arbiter and records access faults reported by three fault sources: an address decode error, a hit on an invalid translation-table page, and a security violation. Each source delivers a one-cycle fault pulse together with the requesting client ID, the access direction, a violation-kind flag and the 32-bit faulting address. The unit records the first fault of each source in that source's own pair of registers: a packed status word, with the address word placed immediately after it. It also raises a sticky pending bit for that source.

Software reads the registers through a simple word-wide register port. It enables sources in an interrupt mask and clears pending bits by writing ones. The interrupt output is a registered OR of the pending bits that are enabled. The fault detection logic itself lives outside this unit.

Top module: `mfault_unit`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A decode fault (source 0) is recorded at byte address 0x10. The client ID is in bits 5:0 and the direction is in bit 31 (1 = write). The faulting address reads at 0x14.
- R3: An invalid-page fault (source 1) is recorded at 0x18. The direction is in bit 0 (1 = write) and the client ID is in bits 6:1, with all other bits 0. The faulting address reads at 0x1C.
- R4: A security fault (source 2) is recorded at 0x20. The client ID is in bits 5:0, the direction is in bit 31 and the violation-kind flag is in bit 30. The faulting address reads at 0x24.
- R5: The kind input of sources 0 and 1 has no effect on their status words.
- R6: While a source's pending bit is set, later faults of that source leave its status and address words unchanged.
- R7: The pending bits read at 0x00, in bits 0, 1 and 2 for sources 0, 1 and 2. They stay set until a write of 1 to the bit clears them. Writing 0 leaves them unchanged.
- R8: A fault that arrives in the same cycle as a clear of its own pending bit is recorded, and the bit stays set.
- R9: `irq` equals the OR of (pending AND mask) delayed by one clock. A masked source still sets its pending bit.
- R10: The mask is read and written at 0x04 in bits 2:0, with bit s enabling source s. Its upper bits read 0.
- R11: Writes to the status and address words are ignored, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_vld | input | 3 | Fault pulse, one bit per source |
| flt_wr | input | 3 | Direction per source, 1 = write |
| flt_kind | input | 3 | Violation-kind flag; only bit 2 is used |
| flt_id | input | 18 | Client IDs, 6 bits per source, source s at [6s+5:6s] |
| flt_addr | input | 96 | Faulting addresses, 32 bits per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a fault that arrives in the very cycle in which software clears that source's pending bit. The stimulus drives the clearing register write and the fault pulse on the same clock edge. It then checks that the new fault's ID and address replaced the old ones while the pending bit remained set. The one-cycle lag of `irq` is sampled on both sides: the cycle after a fault or a clear, when `irq` still holds its old value, and the cycle after that.

// File: rtl/mfault_pkg.sv
package mfault_pkg;
  localparam int NSRC     = 3;
  localparam int SRC_DEC  = 0;
  localparam int SRC_PAGE = 1;
  localparam int SRC_SEC  = 2;

  localparam int OFS_PEND  = 'h00;
  localparam int OFS_MASK  = 'h04;
  localparam int OFS_CAP   = 'h10;
  localparam int CAP_STEP  = 8;

  function automatic int id_lsb(input int s);
    return (s == SRC_PAGE) ? 1 : 0;
  endfunction

  function automatic int dir_pos(input int s);
    return (s == SRC_PAGE) ? 0 : 31;
  endfunction

  function automatic bit kind_used(input int s);
    return (s == SRC_SEC);
  endfunction
endpackage

// File: rtl/mfault_capture.sv
module mfault_capture #(
  parameter int  IDW      = 6,
  parameter int  AW       = 32,
  parameter int  DW       = 32,
  parameter int  ID_LSB   = 0,
  parameter int  DIR_BIT  = 31,
  parameter int  KIND_BIT = 30,
  parameter bit  KIND_EN  = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic [IDW-1:0] id,
  input  logic           wr,
  input  logic           kind,
  input  logic [AW-1:0]  addr,
  output logic [DW-1:0]  stat_word,
  output logic [DW-1:0]  addr_word
);
  logic [IDW-1:0] id_q, id_d;
  logic           wr_q, wr_d;
  logic           kind_q, kind_d;
  logic [AW-1:0]  addr_q, addr_d;

  always_comb begin
    id_d   = id_q;
    wr_d   = wr_q;
    kind_d = kind_q;
    addr_d = addr_q;
    if (cap_en) begin
      id_d   = id;
      wr_d   = wr;
      kind_d = kind & KIND_EN;
      addr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      wr_q   <= 1'b0;
      kind_q <= 1'b0;
      addr_q <= '0;
    end else begin
      id_q   <= id_d;
      wr_q   <= wr_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[ID_LSB +: IDW] = id_q;
    stat_word[DIR_BIT]  = wr_q;
    stat_word[KIND_BIT] = stat_word[KIND_BIT] | kind_q;
    addr_word = '0;
    addr_word[AW-1:0] = addr_q;
  end
endmodule

// File: rtl/mfault_irq_ctrl.sv
module mfault_irq_ctrl #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flt_vld,
  input  logic [NSRC-1:0] clr_req,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  output logic [NSRC-1:0] cap_en,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] mask_q,
  output logic            irq
);
  logic [NSRC-1:0] pend_d, mask_d;
  logic            irq_d;

  always_comb begin
    cap_en = flt_vld & (~pend_q | clr_req);
    pend_d = (pend_q & ~clr_req) | flt_vld;
    mask_d = mask_we ? mask_wdata : mask_q;
    irq_d  = |(pend_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      irq    <= irq_d;
    end
  end
endmodule

// File: rtl/mfault_regs.sv
module mfault_regs #(
  parameter int NSRC = 3,
  parameter int DW   = 32,
  parameter int RAW  = 8
) (
  input  logic             reg_wr,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [NSRC-1:0]  pend_q,
  input  logic [NSRC-1:0]  mask_q,
  input  logic [NSRC*DW-1:0] stat_bus,
  input  logic [NSRC*DW-1:0] addr_bus,
  output logic [NSRC-1:0]  clr_req,
  output logic             mask_we,
  output logic [NSRC-1:0]  mask_wdata,
  output logic [DW-1:0]    reg_rdata
);
  import mfault_pkg::*;

  always_comb begin
    clr_req    = (reg_wr && reg_addr == RAW'(OFS_PEND)) ? reg_wdata[NSRC-1:0] : '0;
    mask_we    = reg_wr && reg_addr == RAW'(OFS_MASK);
    mask_wdata = reg_wdata[NSRC-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(OFS_PEND)) reg_rdata[NSRC-1:0] = pend_q;
    if (reg_addr == RAW'(OFS_MASK)) reg_rdata[NSRC-1:0] = mask_q;
    for (int s = 0; s < NSRC; s++) begin
      if (reg_addr == RAW'(OFS_CAP + s*CAP_STEP))     reg_rdata = stat_bus[s*DW +: DW];
      if (reg_addr == RAW'(OFS_CAP + s*CAP_STEP + 4)) reg_rdata = addr_bus[s*DW +: DW];
    end
  end
endmodule

// File: rtl/mfault_unit.sv
module mfault_unit #(
  parameter int IDW = 6,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RAW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           flt_vld,
  input  logic [2:0]           flt_wr,
  input  logic [2:0]           flt_kind,
  input  logic [3*IDW-1:0]     flt_id,
  input  logic [3*AW-1:0]      flt_addr,
  input  logic                 reg_wr,
  input  logic [RAW-1:0]       reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 irq
);
  import mfault_pkg::*;

  logic [NSRC-1:0]    cap_en, pend_q, mask_q, clr_req, mask_wdata;
  logic               mask_we;
  logic [NSRC*DW-1:0] stat_bus, addr_bus;

  mfault_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .flt_vld(flt_vld), .clr_req(clr_req),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .cap_en(cap_en),
    .pend_q(pend_q), .mask_q(mask_q), .irq(irq)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    mfault_capture #(
      .IDW(IDW), .AW(AW), .DW(DW),
      .ID_LSB(id_lsb(s)), .DIR_BIT(dir_pos(s)), .KIND_BIT(30),
      .KIND_EN(kind_used(s))
    ) u_cap (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en[s]),
      .id(flt_id[s*IDW +: IDW]), .wr(flt_wr[s]), .kind(flt_kind[s]),
      .addr(flt_addr[s*AW +: AW]),
      .stat_word(stat_bus[s*DW +: DW]), .addr_word(addr_bus[s*DW +: DW])
    );
  end

  mfault_regs #(.NSRC(NSRC), .DW(DW), .RAW(RAW)) u_regs (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pend_q(pend_q), .mask_q(mask_q), .stat_bus(stat_bus), .addr_bus(addr_bus),
    .clr_req(clr_req), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/mfault_chk.sv
module mfault_chk #(
  parameter int NSRC = 3,
  parameter int DW   = 32,
  parameter int RAW  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NSRC-1:0]    flt_vld,
  input logic [NSRC-1:0]    pend_q,
  input logic [NSRC-1:0]    mask_q,
  input logic [NSRC-1:0]    clr_req,
  input logic [NSRC*DW-1:0] stat_bus,
  input logic [NSRC*DW-1:0] addr_bus,
  input logic [RAW-1:0]     reg_addr,
  input logic [DW-1:0]      reg_rdata,
  input logic               irq
);
  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(pend_q & mask_q))));

  assert_page_fmt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_bus[DW + 7 +: DW - 7] == '0);

  assert_mask_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RAW'(4)) |-> (reg_rdata[DW-1:NSRC] == '0));

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[s] && !clr_req[s]) |=> pend_q[s]);
    assert_fault_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flt_vld[s] |=> pend_q[s]);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[s] && !clr_req[s]) |=>
        ($stable(stat_bus[s*DW +: DW]) && $stable(addr_bus[s*DW +: DW])));
  end
endmodule

bind mfault_unit mfault_chk #(.NSRC(3), .DW(DW), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_vld(flt_vld), .pend_q(pend_q),
  .mask_q(mask_q), .clr_req(clr_req), .stat_bus(stat_bus),
  .addr_bus(addr_bus), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/sim_mfault_unit.sv
`timescale 1ns/1ps
module sim_mfault_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  flt_vld = '0, flt_wr = '0, flt_kind = '0;
  logic [17:0] flt_id = '0;
  logic [95:0] flt_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mfault_unit u0 (
    .clk(clk), .rst_n(rst_n), .flt_vld(flt_vld), .flt_wr(flt_wr),
    .flt_kind(flt_kind), .flt_id(flt_id), .flt_addr(flt_addr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_fault(input int s, input logic [5:0] id, input logic w,
                           input logic k, input logic [31:0] ad);
    flt_vld[s] = 1'b1; flt_wr[s] = w; flt_kind[s] = k;
    flt_id[s*6 +: 6] = id; flt_addr[s*32 +: 32] = ad;
  endtask

  task automatic fault(input int s, input logic [5:0] id, input logic w,
                       input logic k, input logic [31:0] ad);
    @(negedge clk);
    set_fault(s, id, w, k, ad);
    @(negedge clk);
    flt_vld = '0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq}, 0);
    for (int a = 0; a < 'h28; a += 4) chk_reg("R1 reg", 8'(a), 0);
  endtask

  task automatic t_decode;
    wr('h04, 1);
    fault(0, 6'h2A, 1'b1, 1'b1, 32'hDEAD0010);
    chk("R9 irq lags pending", {31'b0, irq}, 0);
    chk_reg("R2 status", 'h10, 32'h8000_002A);
    chk_reg("R5 kind ignored src0", 'h10, 32'h8000_002A);
    chk_reg("R2 addr", 'h14, 32'hDEAD0010);
    chk_reg("R7 pending", 'h00, 1);
    @(negedge clk);
    chk("R9 irq set", {31'b0, irq}, 1);
  endtask

  task automatic t_hold;
    fault(0, 6'h05, 1'b0, 1'b0, 32'h0000_1111);
    chk_reg("R6 status held", 'h10, 32'h8000_002A);
    chk_reg("R6 addr held", 'h14, 32'hDEAD0010);
  endtask

  task automatic t_clear;
    wr('h00, 0);
    chk_reg("R7 zero write", 'h00, 1);
    wr('h00, 1);
    chk_reg("R7 cleared", 'h00, 0);
    chk("R9 irq still high", {31'b0, irq}, 1);
    @(negedge clk);
    chk("R9 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_page;
    wr('h04, 7);
    fault(1, 6'h3F, 1'b1, 1'b1, 32'h1234_5678);
    chk_reg("R3 status", 'h18, 32'h0000_007F);
    chk_reg("R5 kind ignored src1", 'h18, 32'h0000_007F);
    chk_reg("R3 addr", 'h1C, 32'h1234_5678);
    chk_reg("R7 bit1", 'h00, 2);
  endtask

  task automatic t_sec;
    fault(2, 6'h11, 1'b0, 1'b1, 32'hCAFE_0004);
    chk_reg("R4 status", 'h20, 32'h4000_0011);
    chk_reg("R4 addr", 'h24, 32'hCAFE_0004);
    chk_reg("R7 bits", 'h00, 6);
    wr('h00, 6);
    chk_reg("R7 both cleared", 'h00, 0);
  endtask

  task automatic t_masked;
    wr('h04, 0);
    fault(2, 6'h01, 1'b1, 1'b0, 32'h0);
    chk_reg("R9 masked pending", 'h00, 4);
    @(negedge clk);
    chk("R9 masked no irq", {31'b0, irq}, 0);
    wr('h04, 4);
    @(negedge clk);
    chk("R9 unmask irq", {31'b0, irq}, 1);
    chk_reg("R4 status", 'h20, 32'h8000_0001);
    wr('h00, 4);
  endtask

  task automatic t_race;
    fault(0, 6'h0A, 1'b0, 1'b0, 32'hAAAA_0000);
    @(negedge clk);
    reg_addr = 'h00; reg_wdata = 1; reg_wr = 1'b1;
    set_fault(0, 6'h0B, 1'b1, 1'b0, 32'hBBBB_0000);
    @(negedge clk);
    reg_wr = 1'b0; flt_vld = '0;
    chk_reg("R8 pending kept", 'h00, 1);
    chk_reg("R8 new status", 'h10, 32'h8000_000B);
    chk_reg("R8 new addr", 'h14, 32'hBBBB_0000);
    wr('h00, 1);
  endtask

  task automatic t_ro;
    wr('h10, 32'hFFFF_FFFF);
    wr('h14, 32'hFFFF_FFFF);
    chk_reg("R11 status ro", 'h10, 32'h8000_000B);
    chk_reg("R11 addr ro", 'h14, 32'hBBBB_0000);
    chk_reg("R11 unmapped", 'h3C, 0);
    wr('h04, 32'hFFFF_FFFF);
    chk_reg("R10 mask", 'h04, 7);
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_hold();
    t_clear();
    t_page();
    t_sec();
    t_masked();
    t_race();
    t_ro();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule